// File: doc/BRIEF.md
# Serial Transceiver with Cascaded Bit-Rate Divider

This block is a full-duplex asynchronous serial transceiver. It sits on a small register bus that gives access to a data buffer, a control byte, a status byte and two divider settings. The bit clock is derived from the system clock by two counters in series. The first, a prescaler, divides by `P+1`. The second, a divisor, divides the prescaler output by `D+1`. The result is the oversampling tick. In asynchronous operation each bit lasts sixteen ticks. In synchronous operation each bit lasts one tick, and the `serClk` output marks every tick.

A frame carries 7 or 8 data bits, least significant bit first, and an optional extra bit before the stop bit. The extra bit is either a software-supplied ninth bit or a parity bit. Control bit 3 serves both cases. In nine-bit mode it is the ninth bit to send. In 7/8-bit mode it forms the low half of the parity select, and control bit 4 forms the high half. Receive-buffer-full and transmit-buffer-empty drive two separate interrupt outputs, and each has its own enable bit.

Register map (`regSel`):
- 0 is the data register. A write loads the transmit buffer. A read returns the received byte.
- 1 is the control byte.
- 2 is the status byte.
- 3 is the prescale value `P`.
- 4 is the divisor value `D`.

Control bit fields:
- [1:0]: frame length. 00 = 7 bits, 01 = 8 bits, 10 = 8 bits plus ninth bit.
- [2]: parity enable.
- [3]: ninth bit, or the low bit of the parity select.
- [4]: high bit of the parity select.
- [5]: synchronous mode.
- [6]: receive interrupt enable.
- [7]: transmit interrupt enable.

Status bit fields:
- [0]: transmit buffer empty.
- [1]: receive buffer full.
- [2]: framing error.
- [3]: overrun.
- [4]: parity error.
- [5]: received ninth bit.

Top module: `dualdiv_uart`

## Requirements
- R1: After reset, `txPin` is 1, status reads 8'h01 (transmit buffer empty, nothing else set), and both interrupt outputs are 0.
- R2: In asynchronous mode every transmitted bit lasts exactly 16*(P+1)*(D+1) clock cycles. The prescaler (register 3) stage comes first, ahead of the divisor (register 4).
- R3: A transmitted frame is a 0 start bit, then the data bits LSB first, then the extra bit when one is configured, then a 1 stop bit. Control[1:0] = 00 gives 7 data bits, and 01 or 10 gives 8 data bits.
- R4: With control[1:0] = 10, control bit 3 is sent as the ninth bit after the 8 data bits. A received ninth bit appears in status bit 5.
- R5: With control[1:0] of 00 or 01 and control bit 2 set, a parity bit follows the data. {control[4], control[3]} selects its value: 00 makes the count of ones odd, 01 makes it even, 10 always sends 1, and 11 always sends 0.
- R6: A data-register write clears status bit 0. The bit sets again when the byte moves into the transmitter. `txIrq` equals status bit 0 AND control bit 7.
- R7: The receiver arms on a low line and confirms the start bit on the 8th oversampling tick. A low pulse shorter than that is ignored, and no byte is received.
- R8: A received frame sets status bit 1 and stores the data. `rxIrq` equals status bit 1 AND control bit 6. A read of the data register clears status bit 1.
- R9: A stop bit sampled as 0 sets status bit 2. With parity enabled, a parity mismatch sets status bit 4. Reading the status register clears bits 2, 3 and 4.
- R10: A frame completing while status bit 1 is still set sets status bit 3 and leaves the buffered byte unchanged.
- R11: With control bit 5 set, every transmitted bit lasts (P+1)*(D+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regSel | input | 3 | Register address |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects on read) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational from `regSel` |
| rxPin | input | 1 | Serial input |
| txPin | output | 1 | Serial output, idle high |
| serClk | output | 1 | Tick strobe in synchronous mode |
| rxIrq | output | 1 | Receive buffer full interrupt |
| txIrq | output | 1 | Transmit buffer empty interrupt |

## Verification
Transmit frames are captured bit by bit for each of the following:
- 7-bit and 8-bit payloads.
- All four parity selections, using a payload whose count of ones tells odd apart from even.
- Nine-bit mode, which shows control bit 3 travelling as data rather than as parity.

An alternating 0x55 payload is used to measure a single bit period, in both modes and with unequal prescale and divisor values. This shows that the two divider stages multiply and that the oversampling factor applies only in asynchronous mode.

Received frames cover the following cases:
- A clean byte.
- A ninth-bit byte.
- A byte with a wrong parity bit.
- A byte with a low stop bit.
- Two back-to-back bytes with no read in between.
- A short low glitch.

Together these show that each flag sets only for its own fault, and that the glitch produces no byte at all.

// File: rtl/dualdiv_uart_pkg.sv
package dualdiv_uart_pkg;

  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd1;
  localparam logic [2:0] ADDR_STAT = 3'd2;
  localparam logic [2:0] ADDR_PRE  = 3'd3;
  localparam logic [2:0] ADDR_DIV  = 3'd4;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rxState_t;

  // control -> datapath strobes and configuration
  typedef struct packed {
    logic       loadTx;
    logic [8:0] txWord;    // [8] is the ninth bit
    logic [1:0] lenSel;
    logic       parEn;
    logic [1:0] parSel;
    logic       syncMode;
  } ctl2dp_t;

  // datapath -> control events
  typedef struct packed {
    logic       txIdle;
    logic       rxDone;
    logic [8:0] rxWord;
    logic       frameErr;
    logic       parErr;
  } dp2ctl_t;

  // parity value for a 7/8-bit payload under the 2-bit select
  function automatic logic parityOf(logic [8:0] w, logic sevenBit, logic [1:0] sel);
    logic ones;
    ones = sevenBit ? ^w[6:0] : ^w[7:0];
    case (sel)
      2'd0:    parityOf = ~ones;
      2'd1:    parityOf = ones;
      2'd2:    parityOf = 1'b1;
      default: parityOf = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dualdiv_uart_baud.sv
module dualdiv_uart_baud #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] preVal,
  input  logic [DIV_W-1:0] divVal,
  output logic             sampleTick
);
  logic [PRE_W-1:0] preCnt;
  logic [DIV_W-1:0] divCnt;
  logic             preTick;

  assign preTick    = (preCnt >= preVal);
  assign sampleTick = preTick && (divCnt >= divVal);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt <= '0;
      divCnt <= '0;
    end else begin
      preCnt <= preTick ? '0 : preCnt + 1'b1;
      if (sampleTick)   divCnt <= '0;
      else if (preTick) divCnt <= divCnt + 1'b1;
    end
  end

  // R2: with a prescale above zero, ticks never come on adjacent cycles
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleTick && preVal != '0) |=> (!sampleTick || preVal == '0));

endmodule

// File: rtl/dualdiv_uart_datapath.sv
module dualdiv_uart_datapath
  import dualdiv_uart_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sampleTick,
  input  logic    rxPin,
  input  ctl2dp_t ctl,
  output dp2ctl_t dp,
  output logic    txPin
);
  localparam int FRAME_W = 11;
  localparam int SUB_W   = 4;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [SUB_W-1:0] SUB_LAST = '1;
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(7);

  // frame geometry
  logic [IDX_W-1:0] nData, stopIdx;
  logic is9, hasExtra, extraBit;
  assign nData    = (ctl.lenSel == 2'd0) ? IDX_W'(7) : IDX_W'(8);
  assign is9      = ctl.lenSel[1];
  assign hasExtra = is9 | ctl.parEn;
  assign extraBit = is9 ? ctl.txWord[8]
                        : parityOf(ctl.txWord, ctl.lenSel == 2'd0, ctl.parSel);
  assign stopIdx  = nData + IDX_W'(hasExtra);

  // ---------------- transmitter ----------------
  logic [FRAME_W-1:0] txFrame, txShift;
  logic [IDX_W-1:0]   txLeft;
  logic [SUB_W-1:0]   txSub;
  logic               txBusy;

  always_comb begin
    txFrame    = '1;
    txFrame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (IDX_W'(i) < nData) txFrame[i+1] = ctl.txWord[i];
    if (hasExtra) txFrame[nData + IDX_W'(1)] = extraBit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txBusy  <= 1'b0;
      txShift <= '1;
      txLeft  <= '0;
      txSub   <= '0;
    end else if (ctl.loadTx) begin
      txBusy  <= 1'b1;
      txShift <= txFrame;
      txLeft  <= stopIdx + IDX_W'(1);
      txSub   <= '0;
    end else if (txBusy && sampleTick) begin
      txSub <= txSub + 1'b1;
      if (ctl.syncMode || txSub == SUB_LAST) begin
        if (txLeft == '0) txBusy <= 1'b0;
        else begin
          txShift <= {1'b1, txShift[FRAME_W-1:1]};
          txLeft  <= txLeft - 1'b1;
        end
      end
    end
  end

  assign txPin = txBusy ? txShift[0] : 1'b1;

  // ---------------- receiver ----------------
  rxState_t           rxState;
  logic               rxS1, rxS2;
  logic [SUB_W-1:0]   rxSub;
  logic [IDX_W-1:0]   rxIdx;
  logic [FRAME_W-1:0] rxBits, capt;
  logic [8:0]         word, wordQ;
  logic               extSeen, stopSeen, parBad, doneQ, ferrQ, perrQ;

  always_comb begin
    capt        = rxBits;
    capt[rxIdx] = rxS2;
    word        = '0;
    for (int i = 0; i < 8; i++)
      if (IDX_W'(i) < nData) word[i] = capt[i];
    extSeen  = capt[nData];
    stopSeen = capt[stopIdx];
    word[8]  = is9 & extSeen;
    parBad   = ctl.parEn && !is9 &&
               (extSeen != parityOf(word, ctl.lenSel == 2'd0, ctl.parSel));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxS1    <= 1'b1;
      rxS2    <= 1'b1;
      rxState <= RX_IDLE;
      rxSub   <= '0;
      rxIdx   <= '0;
      rxBits  <= '1;
      doneQ   <= 1'b0;
      wordQ   <= '0;
      ferrQ   <= 1'b0;
      perrQ   <= 1'b0;
    end else begin
      rxS1  <= rxPin;
      rxS2  <= rxS1;
      doneQ <= 1'b0;
      if (sampleTick) begin
        case (rxState)
          RX_IDLE:
            if (!rxS2) begin
              rxIdx   <= '0;
              rxSub   <= ctl.syncMode ? '0 : SUB_W'(1);
              rxState <= ctl.syncMode ? RX_DATA : RX_START;
            end
          RX_START:
            if (rxSub == SUB_MID) begin
              rxSub   <= '0;
              rxState <= rxS2 ? RX_IDLE : RX_DATA;
            end else rxSub <= rxSub + 1'b1;
          default: begin
            rxSub <= rxSub + 1'b1;
            if (ctl.syncMode || rxSub == SUB_LAST) begin
              rxBits <= capt;
              if (rxIdx == stopIdx) begin
                rxState <= RX_IDLE;
                doneQ   <= 1'b1;
                wordQ   <= word;
                ferrQ   <= !stopSeen;
                perrQ   <= parBad;
              end else rxIdx <= rxIdx + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign dp.txIdle   = !txBusy;
  assign dp.rxDone   = doneQ;
  assign dp.rxWord   = wordQ;
  assign dp.frameErr = ferrQ;
  assign dp.parErr   = perrQ;

  // R3: a load always opens the frame with a low start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loadTx |=> !txPin);
  // R3: the last bit of every frame is a high stop bit
  a_r3_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (txBusy && txLeft == '0) |-> txPin);
  // R7: a receive only completes out of the data phase
  a_r7_done_from_data: assert property (@(posedge clk) disable iff (!rst_n)
    doneQ |-> $past(rxState == RX_DATA));

endmodule

// File: rtl/dualdiv_uart_ctrl.sv
module dualdiv_uart_ctrl
  import dualdiv_uart_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  dp2ctl_t          dp,
  output ctl2dp_t          ctl,
  output logic [PRE_W-1:0] preVal,
  output logic [DIV_W-1:0] divVal,
  output logic             rxIrq,
  output logic             txIrq
);
  logic [7:0] ctrlReg, txBuf;
  logic [8:0] rxBuf;
  logic txEmpty, rxFull, frameErr, overrun, parErr;
  logic wrData0, rdData0, rdStat;

  assign wrData0 = wrEn && regSel == ADDR_DATA;
  assign rdData0 = rdEn && regSel == ADDR_DATA;
  assign rdStat  = rdEn && regSel == ADDR_STAT;

  assign ctl.loadTx   = !txEmpty && dp.txIdle;
  assign ctl.txWord   = {ctrlReg[3], txBuf};
  assign ctl.lenSel   = ctrlReg[1:0];
  assign ctl.parEn    = ctrlReg[2];
  assign ctl.parSel   = ctrlReg[4:3];
  assign ctl.syncMode = ctrlReg[5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlReg <= '0; txBuf <= '0; preVal <= '0; divVal <= '0;
      rxBuf <= '0; txEmpty <= 1'b1; rxFull <= 1'b0;
      frameErr <= 1'b0; overrun <= 1'b0; parErr <= 1'b0;
    end else begin
      if (wrEn && regSel == ADDR_CTRL) ctrlReg <= wrData;
      if (wrEn && regSel == ADDR_PRE)  preVal  <= PRE_W'(wrData);
      if (wrEn && regSel == ADDR_DIV)  divVal  <= DIV_W'(wrData);
      if (wrData0) begin
        txBuf   <= wrData;
        txEmpty <= 1'b0;
      end else if (ctl.loadTx) txEmpty <= 1'b1;

      if (rdStat) begin
        frameErr <= 1'b0; overrun <= 1'b0; parErr <= 1'b0;
      end
      if (dp.rxDone) begin
        if (rxFull && !rdData0) overrun <= 1'b1;
        else begin
          rxBuf    <= dp.rxWord;
          rxFull   <= 1'b1;
          frameErr <= dp.frameErr;
          parErr   <= dp.parErr;
        end
      end else if (rdData0) rxFull <= 1'b0;
    end
  end

  always_comb begin
    case (regSel)
      ADDR_DATA: rdData = rxBuf[7:0];
      ADDR_CTRL: rdData = ctrlReg;
      ADDR_STAT: rdData = {2'b00, rxBuf[8], parErr, overrun, frameErr, rxFull, txEmpty};
      ADDR_PRE:  rdData = 8'(preVal);
      ADDR_DIV:  rdData = 8'(divVal);
      default:   rdData = '0;
    endcase
  end

  assign rxIrq = rxFull  & ctrlReg[6];
  assign txIrq = txEmpty & ctrlReg[7];

  // R6: a buffer write always leaves the buffer marked occupied
  a_r6_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    wrData0 |=> !txEmpty);
  // R8: reading the data register with no new arrival empties the buffer
  a_r8_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rdData0 && !dp.rxDone) |=> !rxFull);
  // R10: an arrival onto a full, unread buffer flags overrun and keeps the old byte
  a_r10_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (dp.rxDone && rxFull && !rdData0) |=> (overrun && $stable(rxBuf)));

endmodule

// File: rtl/dualdiv_uart.sv
module dualdiv_uart
  import dualdiv_uart_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       rxPin,
  output logic       txPin,
  output logic       serClk,
  output logic       rxIrq,
  output logic       txIrq
);
  ctl2dp_t          ctl;
  dp2ctl_t          dp;
  logic [PRE_W-1:0] preVal;
  logic [DIV_W-1:0] divVal;
  logic             sampleTick;

  dualdiv_uart_ctrl #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .dp(dp), .ctl(ctl),
    .preVal(preVal), .divVal(divVal), .rxIrq(rxIrq), .txIrq(txIrq));

  dualdiv_uart_baud #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .preVal(preVal), .divVal(divVal),
    .sampleTick(sampleTick));

  dualdiv_uart_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .sampleTick(sampleTick), .rxPin(rxPin),
    .ctl(ctl), .dp(dp), .txPin(txPin));

  assign serClk = ctl.syncMode & sampleTick;

endmodule

// File: tb/dualdiv_uart_bench.sv
module dualdiv_uart_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] regSel = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, rxLine = 1'b1;
  logic [7:0] wrData = '0, rdData;
  logic txPin, serClk, rxIrq, txIrq;
  int checks = 0, errors = 0;
  localparam int BIT = 32;   // P=0, D=1 in async mode

  always #10 clk = ~clk;

  dualdiv_uart u_dualdiv_uart (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .rxPin(rxLine), .txPin(txPin),
    .serClk(serClk), .rxIrq(rxIrq), .txIrq(txIrq));

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regSel = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regSel = a; rdEn = 1'b1; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  // frame built from R3/R4/R5; d[8] is the ninth bit
  task automatic buildFrame(input logic [7:0] cfg, input logic [8:0] d,
                            output logic [10:0] f, output int n);
    int nd; logic ext, eb, ones;
    nd = (cfg[1:0] == 2'd0) ? 7 : 8;
    ext = cfg[1] | cfg[2];
    ones = 1'b0;
    for (int i = 0; i < nd; i++) ones ^= d[i];
    case ({cfg[4], cfg[3]})
      2'd0: eb = ~ones; 2'd1: eb = ones; 2'd2: eb = 1'b1; default: eb = 1'b0;
    endcase
    if (cfg[1]) eb = d[8];
    f = '1; f[0] = 1'b0;
    for (int i = 0; i < nd; i++) f[i+1] = d[i];
    if (ext) f[nd+1] = eb;
    n = nd + (ext ? 1 : 0) + 2;
  endtask

  task automatic captureTx(input int n, output logic [10:0] got);
    got = '1;
    while (txPin) @(negedge clk);
    waitClk(BIT/2);
    got[0] = txPin;
    for (int i = 1; i < n; i++) begin
      waitClk(BIT);
      got[i] = txPin;
    end
    waitClk(BIT);
  endtask

  task automatic driveRx(input logic [10:0] f, input int n, input int stopClk);
    for (int i = 0; i < n - 1; i++) begin
      rxLine = f[i]; waitClk(BIT);
    end
    rxLine = f[n-1]; waitClk(stopClk);
    rxLine = 1'b1; waitClk(BIT);
  endtask

  task automatic t_txFrame(input logic [7:0] cfg, input logic [7:0] b, input string req);
    logic [10:0] f, got; int n;
    busWrite(3'd1, cfg);
    busWrite(3'd0, b);
    buildFrame(cfg, {cfg[3], b}, f, n);
    captureTx(n, got);
    check(got == f, req, {5'd0, got}, {5'd0, f});
  endtask

  task automatic t_bitLen(input logic [7:0] cfg, input logic [7:0] p, input logic [7:0] d,
                          input int exp, input string req);
    int cnt;
    busWrite(3'd3, p); busWrite(3'd4, d); busWrite(3'd1, cfg);
    busWrite(3'd0, 8'h55);
    while (txPin) @(negedge clk);
    while (!txPin) @(negedge clk);
    cnt = 0;
    while (txPin) begin @(negedge clk); cnt++; end
    check(cnt == exp, req, 16'(cnt), 16'(exp));
    waitClk(12 * exp + 8);
    busWrite(3'd3, 8'd0); busWrite(3'd4, 8'd1);
  endtask

  task automatic t_reset;
    logic [7:0] s;
    check(txPin == 1'b1, "R1 txPin idle", {15'd0, txPin}, 16'd1);
    check({rxIrq, txIrq} == 2'b00, "R1 irqs", {14'd0, rxIrq, txIrq}, 16'd0);
    busRead(3'd2, s);
    check(s == 8'h01, "R1 status", {8'd0, s}, 16'h01);
  endtask

  task automatic t_txEmpty;
    logic [7:0] s;
    busWrite(3'd1, 8'h81);
    check(txIrq == 1'b1, "R6 txIrq when empty", {15'd0, txIrq}, 16'd1);
    busWrite(3'd0, 8'h11);
    waitClk(10);
    busWrite(3'd0, 8'h22);
    busRead(3'd2, s);
    check(s[0] == 1'b0 && txIrq == 1'b0, "R6 empty cleared by write",
          {8'd0, s[0], txIrq, 6'd0}, 16'd0);
    waitClk(24 * BIT);
    busRead(3'd2, s);
    check(s[0] == 1'b1 && txIrq == 1'b1, "R6 empty after transfer",
          {8'd0, s[0], txIrq, 6'd0}, 16'hC0);
    busWrite(3'd1, 8'h01);
  endtask

  task automatic t_rxClean;
    logic [10:0] f; int n; logic [7:0] s, d;
    busWrite(3'd1, 8'h41);
    buildFrame(8'h41, 9'h0B6, f, n);
    driveRx(f, n, BIT);
    busRead(3'd2, s);
    check(s[5:1] == 5'b00001 && rxIrq, "R8 full and irq", {8'd0, s}, 16'h03);
    busRead(3'd0, d);
    check(d == 8'hB6, "R8 data", {8'd0, d}, 16'hB6);
    busRead(3'd2, s);
    check(s[1] == 1'b0 && !rxIrq, "R8 read clears full", {8'd0, s}, 16'h01);
  endtask

  task automatic t_rxNinth;
    logic [10:0] f; int n; logic [7:0] s, d;
    busWrite(3'd1, 8'h02);
    buildFrame(8'h02, 9'h15A, f, n);
    driveRx(f, n, BIT);
    busRead(3'd2, s);
    check(s[5] == 1'b1 && s[4:2] == 3'b000, "R4 ninth bit received", {8'd0, s}, 16'h23);
    busRead(3'd0, d);
    check(d == 8'h5A, "R4 ninth-mode data", {8'd0, d}, 16'h5A);
  endtask

  task automatic t_rxGlitch;
    logic [7:0] s;
    busWrite(3'd1, 8'h01);
    rxLine = 1'b0; waitClk(8); rxLine = 1'b1;
    waitClk(14 * BIT);
    busRead(3'd2, s);
    check(s[1] == 1'b0, "R7 glitch ignored", {8'd0, s}, 16'h01);
  endtask

  task automatic t_rxErrors;
    logic [10:0] f; int n; logic [7:0] s, d;
    busWrite(3'd1, 8'h01);
    buildFrame(8'h01, 9'h081, f, n);
    f[n-1] = 1'b0;
    driveRx(f, n, 20);
    busRead(3'd2, s);
    check(s[2] == 1'b1 && s[4] == 1'b0, "R9 framing error", {8'd0, s}, 16'h07);
    busRead(3'd0, d);
    busRead(3'd2, s);
    check(s[4:2] == 3'b000, "R9 status read clears", {8'd0, s}, 16'h01);
    busWrite(3'd1, 8'h0D);       // 8-bit, parity on, even
    buildFrame(8'h0D, 9'h003, f, n);
    f[9] = ~f[9];
    driveRx(f, n, BIT);
    busRead(3'd2, s);
    check(s[4] == 1'b1 && s[2] == 1'b0, "R9 parity error", {8'd0, s}, 16'h13);
    busRead(3'd0, d);
    busRead(3'd2, s);
  endtask

  task automatic t_rxOverrun;
    logic [10:0] f; int n; logic [7:0] s, d;
    busWrite(3'd1, 8'h01);
    buildFrame(8'h01, 9'h03C, f, n);
    driveRx(f, n, BIT);
    buildFrame(8'h01, 9'h0C3, f, n);
    driveRx(f, n, BIT);
    busRead(3'd2, s);
    check(s[3] == 1'b1 && s[1] == 1'b1, "R10 overrun flag", {8'd0, s}, 16'h0B);
    busRead(3'd0, d);
    check(d == 8'h3C, "R10 first byte kept", {8'd0, d}, 16'h3C);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitClk(3);
    rst_n = 1'b1;
    waitClk(2);
    t_reset();
    busWrite(3'd4, 8'd1);
    t_txFrame(8'h01, 8'hA5, "R3 8-bit frame");
    t_txFrame(8'h00, 8'h4B, "R3 7-bit frame");
    t_txFrame(8'h05, 8'h07, "R5 odd parity");
    t_txFrame(8'h0C, 8'h35, "R5 even parity 7-bit");
    t_txFrame(8'h15, 8'h07, "R5 mark parity");
    t_txFrame(8'h1D, 8'h06, "R5 space parity");
    t_txFrame(8'h0A, 8'hC3, "R4 ninth bit sent");
    t_bitLen(8'h01, 8'd1, 8'd2, 96, "R2 cascaded bit period");
    t_bitLen(8'h21, 8'd0, 8'd3, 4, "R11 sync bit period");
    busWrite(3'd1, 8'h01);
    waitClk(40);
    t_txEmpty();
    t_rxClean();
    t_rxNinth();
    t_rxGlitch();
    t_rxErrors();
    t_rxOverrun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule